// File: doc/BRIEF.md
# Panel Self-Refresh Idle Controller

This block decides when a display pipeline may rest and let the panel refresh itself from its own frame memory. It counts millisecond tick pulses since the last frame-update request. When the idle window runs out in normal operation, it tells the panel to take over refresh. It then keeps the display timing and all three clock domains alive for a settle interval, so the panel captures further complete frames. After that it shuts the pipeline down one step at a time.

A later update request, or a force-leave pulse, brings the pipeline back up in the mirrored order. The panel-refresh request is released only after the display timing is running again. A suspend pulse takes the pipeline down at once and blocks idle entry until a resume pulse restores normal operation. Two status outputs report whether self-refresh is in force and whether the clocks are considered running.

Top module: `psr_idle_ctrl`

## Requirements
- R1: After reset, core, pixel and pad clock enables and the timing enable are 1, panel_refresh_en is 0, idle_mode is 0 and clocks_on is 1.
- R2: In normal mode, once IDLE_MS tick pulses have passed with no update request, the next clock edge raises panel_refresh_en and idle_mode while every clock and timing enable stays 1.
- R3: After entry, timing and all clock enables remain 1 until SETTLE_MS further ticks have been counted.
- R4: After the settle interval the enables fall in the order timing, pad, pixel, core, one per tick-qualified cycle; clocks_on falls together with the core enable.
- R5: An update request while self-refresh is in force raises core, pixel, pad, then timing, then clears panel_refresh_en, one per tick-qualified cycle; clocks_on rises with timing and idle_mode falls with panel_refresh_en.
- R6: Every update request restarts the idle window, so requests spaced closer than IDLE_MS ticks keep the block in normal mode.
- R7: An update request during the settle interval or during the shutdown steps abandons entry and starts the wake sequence of R5.
- R8: A force_leave pulse while self-refresh is in force runs the same wake sequence as R5; in normal mode it has no effect.
- R9: A suspend pulse while the block is fully shut down only clears panel_refresh_en; the clock and timing enables stay 0.
- R10: A suspend pulse in any other non-suspended state clears timing and all three clock enables at the next edge, leaves panel_refresh_en unchanged, and clears idle_mode and clocks_on. While suspended, update requests and ticks change nothing.
- R11: A resume pulse while suspended sets all clock and timing enables and clocks_on to 1 and clears panel_refresh_en at the next edge. A new full idle window is then required before entry.
- R12: Outside suspend and resume, no clock or timing enable changes in a cycle that has no tick pulse.
- R13: idle_mode is 1 from entry until the end of a wake sequence; clocks_on is 0 from the core clock shutdown until timing is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond tick pulse |
| upd_req | input | 1 | Frame-update request pulse |
| force_leave | input | 1 | Request to leave self-refresh immediately |
| suspend_req | input | 1 | Suspend pulse |
| resume_req | input | 1 | Resume pulse |
| panel_refresh_en | output | 1 | Panel self-refresh request |
| core_clk_en | output | 1 | Core clock enable |
| pix_clk_en | output | 1 | Pixel clock enable |
| pad_clk_en | output | 1 | Pad clock enable |
| timing_en | output | 1 | Display timing generator enable |
| idle_mode | output | 1 | Self-refresh in force |
| clocks_on | output | 1 | Clocks considered running |

## Verification
On every cycle the assertions check the enable ordering invariants: pad needs pixel, pixel needs core, and timing needs pad. They also check that a stopped timing generator outside suspend always comes with the panel refresh request held, that at most one enable moves per cycle, and that none moves without a tick. The exact length of the idle and settle windows, the abort of an entry by a late update, and the two suspend outcomes depend on the history of requests. Only the bench's scenarios show these, against a reference model that follows the block cycle by cycle under different tick spacings.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_SETTLE,
        ST_DN_TIM,
        ST_DN_PAD,
        ST_DN_PIX,
        ST_DN_CORE,
        ST_IDLE,
        ST_UP_CORE,
        ST_UP_PIX,
        ST_UP_PAD,
        ST_UP_TIM,
        ST_UP_REF,
        ST_SUSP
    } psr_state_e;

    typedef struct packed {
        logic refresh;
        logic core;
        logic pix;
        logic pad;
        logic timing;
    } psr_drive_t;

    localparam psr_drive_t DRIVE_RUN  = '{refresh: 1'b0, core: 1'b1, pix: 1'b1, pad: 1'b1, timing: 1'b1};

    // States in which self-refresh is committed and a wake may be requested
    function automatic logic may_wake(psr_state_e s);
        return (s == ST_SETTLE) || (s == ST_DN_TIM) || (s == ST_DN_PAD) ||
               (s == ST_DN_PIX) || (s == ST_DN_CORE) || (s == ST_IDLE);
    endfunction

    function automatic int unsigned count_width(int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/psr_tick_timer.sv
module psr_tick_timer #(
    parameter int unsigned LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    import psr_pkg::*;

    localparam int unsigned W = count_width(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);

    // R6: the window counter saturates at its limit
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM);

    // R6: a restart always begins a fresh window
    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

endmodule

// File: rtl/psr_seq.sv
module psr_seq (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 upd_req,
    input  logic                 force_leave,
    input  logic                 suspend_req,
    input  logic                 resume_req,
    input  logic                 idle_expired,
    input  logic                 settle_expired,
    output psr_pkg::psr_state_e  state,
    output psr_pkg::psr_drive_t  drive,
    output logic                 idle_flag,
    output logic                 clk_flag
);
    import psr_pkg::*;

    logic wake_hit;
    assign wake_hit = may_wake(state) && (force_leave || upd_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            drive     <= DRIVE_RUN;
            idle_flag <= 1'b0;
            clk_flag  <= 1'b1;
        end else if (suspend_req && state != ST_SUSP) begin
            state     <= ST_SUSP;
            idle_flag <= 1'b0;
            clk_flag  <= 1'b0;
            if (state == ST_IDLE) begin
                drive.refresh <= 1'b0;
            end else begin
                drive.core   <= 1'b0;
                drive.pix    <= 1'b0;
                drive.pad    <= 1'b0;
                drive.timing <= 1'b0;
            end
        end else if (state == ST_SUSP) begin
            if (resume_req) begin
                state    <= ST_RUN;
                drive    <= DRIVE_RUN;
                clk_flag <= 1'b1;
            end
        end else if (wake_hit) begin
            state <= ST_UP_CORE;
        end else begin
            unique case (state)
                ST_RUN: if (idle_expired && !upd_req) begin
                    drive.refresh <= 1'b1;
                    idle_flag     <= 1'b1;
                    state         <= ST_SETTLE;
                end
                ST_SETTLE: if (settle_expired) state <= ST_DN_TIM;
                ST_DN_TIM: if (tick) begin
                    drive.timing <= 1'b0;
                    state        <= ST_DN_PAD;
                end
                ST_DN_PAD: if (tick) begin
                    drive.pad <= 1'b0;
                    state     <= ST_DN_PIX;
                end
                ST_DN_PIX: if (tick) begin
                    drive.pix <= 1'b0;
                    state     <= ST_DN_CORE;
                end
                ST_DN_CORE: if (tick) begin
                    drive.core <= 1'b0;
                    clk_flag   <= 1'b0;
                    state      <= ST_IDLE;
                end
                ST_UP_CORE: if (tick) begin
                    drive.core <= 1'b1;
                    state      <= ST_UP_PIX;
                end
                ST_UP_PIX: if (tick) begin
                    drive.pix <= 1'b1;
                    state     <= ST_UP_PAD;
                end
                ST_UP_PAD: if (tick) begin
                    drive.pad <= 1'b1;
                    state     <= ST_UP_TIM;
                end
                ST_UP_TIM: if (tick) begin
                    drive.timing <= 1'b1;
                    clk_flag     <= 1'b1;
                    state        <= ST_UP_REF;
                end
                ST_UP_REF: if (tick) begin
                    drive.refresh <= 1'b0;
                    idle_flag     <= 1'b0;
                    state         <= ST_RUN;
                end
                default: state <= state;
            endcase
        end
    end

    // R4: a clock is only enabled when the clock closer to the core is
    assert_clk_chain_R4: assert property (@(posedge clk) disable iff (rst)
        (!drive.pad || drive.pix) && (!drive.pix || drive.core));

    // R5: timing only runs on a fully clocked pipeline
    assert_timing_needs_pad_R5: assert property (@(posedge clk) disable iff (rst)
        drive.timing |-> drive.pad);

    // R3: a stopped timing generator outside suspend implies panel self-refresh
    assert_dark_means_refresh_R3: assert property (@(posedge clk) disable iff (rst)
        (!drive.timing && state != ST_SUSP) |-> drive.refresh);

    // R3: the settle interval keeps everything streaming
    assert_settle_live_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE) |-> (drive.core && drive.pix && drive.pad && drive.timing));

    // R12: enables only move on tick cycles unless suspend or resume acts
    assert_step_on_tick_R12: assert property (@(posedge clk) disable iff (rst)
        (!tick && !suspend_req && !resume_req) |=>
            $stable({drive.core, drive.pix, drive.pad, drive.timing}));

    // R4: at most one enable changes per sequencing step
    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!suspend_req && !resume_req) |=>
            ($countones({drive.core, drive.pix, drive.pad, drive.timing} ^
                        $past({drive.core, drive.pix, drive.pad, drive.timing})) <= 1));

endmodule

// File: rtl/psr_idle_ctrl.sv
module psr_idle_ctrl #(
    parameter int unsigned IDLE_MS   = 200,
    parameter int unsigned SETTLE_MS = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_ms,
    input  logic upd_req,
    input  logic force_leave,
    input  logic suspend_req,
    input  logic resume_req,
    output logic panel_refresh_en,
    output logic core_clk_en,
    output logic pix_clk_en,
    output logic pad_clk_en,
    output logic timing_en,
    output logic idle_mode,
    output logic clocks_on
);
    import psr_pkg::*;

    psr_state_e state;
    psr_drive_t drive;
    logic       idle_expired;
    logic       settle_expired;
    logic       idle_restart;
    logic       settle_restart;

    assign idle_restart   = upd_req || (state != ST_RUN);
    assign settle_restart = (state != ST_SETTLE);

    psr_tick_timer #(.LIMIT(IDLE_MS)) u_idle_win (
        .clk     (clk),
        .rst     (rst),
        .restart (idle_restart),
        .tick    (tick_ms),
        .expired (idle_expired)
    );

    psr_tick_timer #(.LIMIT(SETTLE_MS)) u_settle_win (
        .clk     (clk),
        .rst     (rst),
        .restart (settle_restart),
        .tick    (tick_ms),
        .expired (settle_expired)
    );

    psr_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .tick           (tick_ms),
        .upd_req        (upd_req),
        .force_leave    (force_leave),
        .suspend_req    (suspend_req),
        .resume_req     (resume_req),
        .idle_expired   (idle_expired),
        .settle_expired (settle_expired),
        .state          (state),
        .drive          (drive),
        .idle_flag      (idle_mode),
        .clk_flag       (clocks_on)
    );

    assign panel_refresh_en = drive.refresh;
    assign core_clk_en      = drive.core;
    assign pix_clk_en       = drive.pix;
    assign pad_clk_en       = drive.pad;
    assign timing_en        = drive.timing;

    // R13: clocks are reported running whenever timing is enabled
    assert_status_clk_R13: assert property (@(posedge clk) disable iff (rst)
        timing_en |-> clocks_on);

endmodule

// File: tb/psr_idle_ctrl_tb.sv
module psr_idle_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IDLE_MS    = 200;
    localparam int SETTLE_MS  = 48;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ms = 1'b0, upd_req = 1'b0, force_leave = 1'b0;
    logic suspend_req = 1'b0, resume_req = 1'b0;
    logic panel_refresh_en, core_clk_en, pix_clk_en, pad_clk_en, timing_en;
    logic idle_mode, clocks_on;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int tick_div = 2;
    int tick_cnt = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_idle_ctrl #(.IDLE_MS(IDLE_MS), .SETTLE_MS(SETTLE_MS)) dut_i (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .upd_req(upd_req),
        .force_leave(force_leave), .suspend_req(suspend_req), .resume_req(resume_req),
        .panel_refresh_en(panel_refresh_en), .core_clk_en(core_clk_en),
        .pix_clk_en(pix_clk_en), .pad_clk_en(pad_clk_en), .timing_en(timing_en),
        .idle_mode(idle_mode), .clocks_on(clocks_on)
    );

    // Reference model: phase 0 normal, 1 settle, 2..5 shutdown steps
    // (timing, pad, pixel, core), 6 rest, 7..11 wake steps (core, pixel,
    // pad, timing, refresh release), 12 suspended.
    int ph = 0;
    int idle_ticks = 0;
    int settle_ticks = 0;
    bit m_ref = 0, m_core = 1, m_pix = 1, m_pad = 1, m_tim = 1, m_idle = 0, m_clk = 1;

    always @(posedge clk) begin
        int old_ph, old_it, old_st;
        old_ph = ph; old_it = idle_ticks; old_st = settle_ticks;
        if (rst) begin
            ph = 0; idle_ticks = 0; settle_ticks = 0;
            {m_ref, m_core, m_pix, m_pad, m_tim, m_idle, m_clk} = 7'b0111101;
        end else begin
            if (upd_req || old_ph != 0) idle_ticks = 0;
            else if (tick_ms && idle_ticks < IDLE_MS) idle_ticks++;
            if (old_ph != 1) settle_ticks = 0;
            else if (tick_ms && settle_ticks < SETTLE_MS) settle_ticks++;

            if (suspend_req && old_ph != 12) begin
                if (old_ph == 6) m_ref = 0;
                else {m_core, m_pix, m_pad, m_tim} = 4'b0000;
                m_idle = 0; m_clk = 0; ph = 12;
            end else if (old_ph == 12) begin
                if (resume_req) begin
                    {m_ref, m_core, m_pix, m_pad, m_tim} = 5'b01111;
                    m_clk = 1; ph = 0;
                end
            end else if (old_ph >= 1 && old_ph <= 6 && (force_leave || upd_req)) begin
                ph = 7;
            end else if (old_ph == 0) begin
                if (old_it >= IDLE_MS && !upd_req) begin
                    m_ref = 1; m_idle = 1; ph = 1;
                end
            end else if (old_ph == 1) begin
                if (old_st >= SETTLE_MS) ph = 2;
            end else if (tick_ms && old_ph >= 2 && old_ph <= 5) begin
                case (old_ph)
                    2: m_tim = 0;
                    3: m_pad = 0;
                    4: m_pix = 0;
                    default: begin m_core = 0; m_clk = 0; end
                endcase
                ph = old_ph + 1;
            end else if (tick_ms && old_ph >= 7 && old_ph <= 11) begin
                case (old_ph)
                    7: m_core = 1;
                    8: m_pix = 1;
                    9: m_pad = 1;
                    10: begin m_tim = 1; m_clk = 1; end
                    default: begin m_ref = 0; m_idle = 0; end
                endcase
                ph = (old_ph == 11) ? 0 : old_ph + 1;
            end
        end
    end

    function automatic logic [6:0] dut_vec();
        return {panel_refresh_en, core_clk_en, pix_clk_en, pad_clk_en, timing_en, idle_mode, clocks_on};
    endfunction

    task automatic chk(input string req, input logic [6:0] exp);
        checks++;
        if (dut_vec() !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, dut_vec(), exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) chk(cur_req, {m_ref, m_core, m_pix, m_pad, m_tim, m_idle, m_clk});
        tick_cnt++;
        tick_ms = (tick_div <= 1) ? 1'b1 : ((tick_cnt % tick_div) == 0);
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_upd();   @(negedge clk); upd_req = 1;     @(negedge clk); upd_req = 0;     endtask
    task automatic pulse_force(); @(negedge clk); force_leave = 1; @(negedge clk); force_leave = 0; endtask
    task automatic pulse_susp();  @(negedge clk); suspend_req = 1; @(negedge clk); suspend_req = 0; endtask
    task automatic pulse_res();   @(negedge clk); resume_req = 1;  @(negedge clk); resume_req = 0;  endtask

    localparam logic [6:0] V_RUN  = 7'b0111101;
    localparam logic [6:0] V_SETL = 7'b1111111;
    localparam logic [6:0] V_REST = 7'b1000010;
    localparam logic [6:0] V_OFF  = 7'b0000000;

    initial begin
        wait_cyc(3);
        rst = 0;
        @(negedge clk);
        chk("R1", V_RUN);

        // R6: updates closer than the window keep normal mode
        cur_req = "R6";
        for (int i = 0; i < 3; i++) begin
            wait_cyc(300);
            pulse_upd();
            chk("R6", V_RUN);
        end
        wait_cyc(380);
        chk("R6", V_RUN);

        // R2/R3: entry then settle with everything streaming
        cur_req = "R2";
        wait_cyc(40);
        chk("R2", V_SETL);
        cur_req = "R4";
        wait_cyc(200);
        chk("R4", V_REST);
        chk("R13", V_REST);

        // R5: update wakes the pipeline
        cur_req = "R5";
        pulse_upd();
        wait_cyc(20);
        chk("R5", V_RUN);

        // R7: update during settle aborts entry
        cur_req = "R7";
        wait_cyc(450);
        chk("R3", V_SETL);
        pulse_upd();
        wait_cyc(20);
        chk("R7", V_RUN);

        // R8: force leave from rest, and no effect in normal mode
        cur_req = "R8";
        pulse_force();
        chk("R8", V_RUN);
        wait_cyc(700);
        chk("R8", V_REST);
        pulse_force();
        wait_cyc(20);
        chk("R8", V_RUN);

        // R12/R7: slow ticks, update during the shutdown steps
        cur_req = "R12";
        tick_div = 6;
        for (int g = 0; g < 5000 && timing_en; g++) @(negedge clk);
        chk("R12", 7'b1111011);
        @(negedge clk);
        chk("R12", 7'b1111011);
        cur_req = "R7";
        pulse_upd();
        wait_cyc(60);
        chk("R7", V_RUN);

        // R10/R11: suspend from normal mode, then resume
        cur_req = "R10";
        tick_div = 2;
        pulse_susp();
        chk("R10", V_OFF);
        wait_cyc(1000);
        pulse_upd();
        chk("R10", V_OFF);
        cur_req = "R11";
        pulse_res();
        chk("R11", V_RUN);
        wait_cyc(380);
        chk("R11", V_RUN);

        // R10: suspend during settle leaves refresh request set
        cur_req = "R10";
        wait_cyc(60);
        chk("R3", V_SETL);
        pulse_susp();
        chk("R10", 7'b1000000);
        pulse_res();
        chk("R11", V_RUN);

        // R9: suspend from rest only drops the refresh request
        cur_req = "R9";
        wait_cyc(700);
        chk("R9", V_REST);
        pulse_susp();
        chk("R9", V_OFF);
        pulse_res();
        chk("R11", V_RUN);
        wait_cyc(10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule